// File: doc/BRIEF.md
# Rail Fault Tally and Shutdown Latch

This block keeps a running tally of power-rail faults and decides which rails to switch off. Each supervised rail has a disable latch. An undervoltage pulse on a rail sets that rail's latch. The memory supply rail also takes an overcurrent pulse, which has the same effect. A rail that is powered from another rail is marked as faulted one clock after its source rail is disabled. That marking counts as a second, separate event.

Overvoltage on the memory supply rail or on the memory termination rail sets a global shutdown latch. This latch survives everything except a pass through the soft-off state. A quiet-time timer restarts on every counted fault. If it runs a long stretch of clocks with no fault, it clears the tally. When the system is restarting out of soft-off, a tally that reaches the trip count forces the global shutdown.

All fault inputs are synchronous single-cycle pulses from comparators outside the block. Surrounding sequencing logic provides the soft-off flag and the restart indication.

Top module: `fc_fault_tally`

## Requirements
- R11: After reset all rail disable bits are 0, the shutdown latch is 0 and the fault count is 0.
- R1: An undervoltage pulse on rail i, or an overcurrent pulse (which applies to rail 0, the memory supply), sets bit i of `rail_off` at that clock edge. No other rail bit changes, and the bit holds until soft-off.
- R2: At every edge, the count rises by the number of events at that edge. Each rail newly faulted counts as one event. An overvoltage pulse counts as one event, and each of the two overvoltage pulses counts separately.
- R3: The fault count saturates at 2^CNT_W-1 and does not wrap.
- R4: A fault pulse on a rail whose disable bit is already set is ignored. It does not add to the count and does not restart the quiet timer.
- R5: The count returns to 0 at the QUIET_LIMIT-th consecutive clock edge with no counted event. A counted event restarts that window. Clearing the count leaves the rail bits unchanged.
- R6: When the source rail of a fed rail is disabled, the fed rail's bit is set one edge later and adds one to the count. By default rail 1 is fed from rail 0 and rail 3 from rail 2.
- R7: An overvoltage pulse on either the memory supply or the memory termination rail sets `shutdown` at that edge.
- R8: Once set, `shutdown` stays set while `soft_off` is high. It clears at the first edge where `soft_off` is low after having been high.
- R9: While `restart_active` is high, `shutdown` is set at the same edge where the updated count becomes TRIP_COUNT (4) or more. With `restart_active` low, the same count does not set it.
- R10: While `soft_off` is high, all rail bits and the count are held at 0 and every fault pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (nominally 250 kHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_pulse | input | N_RAILS | Per-rail undervoltage pulses; bit 0 is the memory supply |
| oc_mem_pulse | input | 1 | Overcurrent pulse for the memory supply rail |
| ov_mem_pulse | input | 1 | Overvoltage pulse, memory supply rail |
| ov_term_pulse | input | 1 | Overvoltage pulse, memory termination rail |
| restart_active | input | 1 | High while restarting from soft-off into active |
| soft_off | input | 1 | High while the system is in the soft-off state |
| rail_off | output | N_RAILS | Per-rail disable latches |
| shutdown | output | 1 | Latched shutdown of all rails |
| fault_count | output | CNT_W | Current saturating fault tally |

## Verification
The assertions assume every fault input is a clean level, already synchronous to `clk`, that changes only between edges. They also assume that `soft_off` and `restart_active` come from sequencing logic and are never high together with reset. The bench drives all inputs on the falling edge and samples after the rising edge. It holds each pulse for exactly one clock unless a multi-cycle level is the point of the test. It keeps the quiet window short so that both sides of the expiry edge can be seen.

// File: rtl/fc_pkg.sv
package fc_pkg;

  // number of set bits in a vector of up to 32 bits
  function automatic int unsigned pop_count(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  // add with a ceiling instead of wrap-around
  function automatic int unsigned sat_add(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned ceil);
    int unsigned s;
    s = a + b;
    return (s > ceil) ? ceil : s;
  endfunction

endpackage

// File: rtl/fc_event_merge.sv
module fc_event_merge #(
  parameter int N_RAILS = 4,
  parameter int IDX_W   = 2,
  parameter int MEM_IDX = 0,
  parameter logic [N_RAILS-1:0][IDX_W-1:0] FEED_SRC = '0,
  parameter int EVW     = 3
) (
  input  logic [N_RAILS-1:0] uv_pulse,
  input  logic               oc_mem_pulse,
  input  logic               ov_mem_pulse,
  input  logic               ov_term_pulse,
  input  logic [N_RAILS-1:0] rail_off,
  input  logic               soft_off,
  output logic [N_RAILS-1:0] rail_hit,
  output logic               ov_hit,
  output logic               any_event,
  output logic [EVW-1:0]     ev_count
);
  import fc_pkg::*;

  for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
    logic direct;
    logic cascade;
    if (i == MEM_IDX) begin : g_mem
      assign direct = uv_pulse[i] | oc_mem_pulse;
    end else begin : g_plain
      assign direct = uv_pulse[i];
    end
    if (FEED_SRC[i] != IDX_W'(i)) begin : g_fed
      assign cascade = rail_off[FEED_SRC[i]];
    end else begin : g_root
      assign cascade = 1'b0;
    end
    assign rail_hit[i] = (direct | cascade) & ~rail_off[i] & ~soft_off;
  end

  logic [1:0] ov_vec;
  assign ov_vec    = {ov_term_pulse, ov_mem_pulse} & {2{~soft_off}};
  assign ov_hit    = |ov_vec;
  assign any_event = ov_hit | (|rail_hit);
  assign ev_count  = EVW'(pop_count(32'(rail_hit)) + pop_count(32'(ov_vec)));

endmodule

// File: rtl/fc_quiet_timer.sv
module fc_quiet_timer #(
  parameter int QUIET_LIMIT = 16384,
  parameter int QW          = $clog2(QUIET_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expire
);
  localparam logic [QW-1:0] LIMIT_V = QW'(QUIET_LIMIT);
  localparam logic [QW-1:0] LAST_V  = QW'(QUIET_LIMIT - 1);

  logic [QW-1:0] quiet_q;

  assign expire = !restart && (quiet_q == LAST_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                quiet_q <= '0;
    else if (restart)          quiet_q <= '0;
    else if (quiet_q < LIMIT_V) quiet_q <= quiet_q + 1'b1;
  end

endmodule

// File: rtl/fc_tally.sv
module fc_tally #(
  parameter int CNT_W = 3,
  parameter int EVW   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             expire,
  input  logic [EVW-1:0]   ev_count,
  output logic [CNT_W-1:0] tally,
  output logic [CNT_W-1:0] tally_nxt
);
  import fc_pkg::*;
  localparam int unsigned CEIL = (1 << CNT_W) - 1;

  always_comb begin
    if (clear_all || expire) tally_nxt = '0;
    else tally_nxt = CNT_W'(sat_add(int'(tally), int'(ev_count), CEIL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tally <= '0;
    else        tally <= tally_nxt;
  end

endmodule

// File: rtl/fc_fault_tally.sv
module fc_fault_tally #(
  parameter int N_RAILS     = 4,
  parameter int CNT_W       = 3,
  parameter int QUIET_LIMIT = 16384,
  parameter int TRIP_COUNT  = 4,
  parameter int MEM_IDX     = 0,
  parameter int IDX_W       = (N_RAILS > 1) ? $clog2(N_RAILS) : 1,
  parameter logic [N_RAILS-1:0][IDX_W-1:0] FEED_SRC = {2'd2, 2'd2, 2'd0, 2'd0}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_RAILS-1:0] uv_pulse,
  input  logic               oc_mem_pulse,
  input  logic               ov_mem_pulse,
  input  logic               ov_term_pulse,
  input  logic               restart_active,
  input  logic               soft_off,
  output logic [N_RAILS-1:0] rail_off,
  output logic               shutdown,
  output logic [CNT_W-1:0]   fault_count
);
  localparam int EVW = $clog2(N_RAILS + 3);
  localparam logic [CNT_W-1:0] TRIP_V = CNT_W'(TRIP_COUNT);

  logic [N_RAILS-1:0] rail_hit;
  logic               ov_hit;
  logic               any_event;
  logic [EVW-1:0]     ev_count;
  logic               expire;
  logic [CNT_W-1:0]   tally_nxt;
  logic               trip_hit;
  logic               leave_soft_off;
  logic               soft_off_q;
  logic [N_RAILS-1:0] rail_off_q;
  logic               shutdown_q;

  fc_event_merge #(
    .N_RAILS(N_RAILS), .IDX_W(IDX_W), .MEM_IDX(MEM_IDX),
    .FEED_SRC(FEED_SRC), .EVW(EVW)
  ) i_merge (
    .uv_pulse(uv_pulse), .oc_mem_pulse(oc_mem_pulse),
    .ov_mem_pulse(ov_mem_pulse), .ov_term_pulse(ov_term_pulse),
    .rail_off(rail_off_q), .soft_off(soft_off),
    .rail_hit(rail_hit), .ov_hit(ov_hit),
    .any_event(any_event), .ev_count(ev_count)
  );

  fc_quiet_timer #(.QUIET_LIMIT(QUIET_LIMIT)) i_quiet (
    .clk(clk), .rst_n(rst_n),
    .restart(any_event | soft_off),
    .expire(expire)
  );

  fc_tally #(.CNT_W(CNT_W), .EVW(EVW)) i_tally (
    .clk(clk), .rst_n(rst_n),
    .clear_all(soft_off), .expire(expire), .ev_count(ev_count),
    .tally(fault_count), .tally_nxt(tally_nxt)
  );

  assign trip_hit       = restart_active && !soft_off && (tally_nxt >= TRIP_V);
  assign leave_soft_off = soft_off_q && !soft_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rail_off_q <= '0;
      soft_off_q <= 1'b0;
      shutdown_q <= 1'b0;
    end else begin
      soft_off_q <= soft_off;
      rail_off_q <= soft_off ? '0 : (rail_off_q | rail_hit);
      if (ov_hit || trip_hit) shutdown_q <= 1'b1;
      else if (leave_soft_off) shutdown_q <= 1'b0;
    end
  end

  assign rail_off = rail_off_q;
  assign shutdown = shutdown_q;

endmodule

// File: rtl/fc_fault_tally_chk.sv
module fc_fault_tally_chk #(
  parameter int N_RAILS = 4,
  parameter int CNT_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               soft_off,
  input logic               ov_mem_pulse,
  input logic               ov_term_pulse,
  input logic [N_RAILS-1:0] rail_off,
  input logic               shutdown,
  input logic [CNT_W-1:0]   fault_count,
  input logic [N_RAILS-1:0] rail_hit,
  input logic               expire,
  input logic               trip_hit
);
  localparam logic [CNT_W-1:0] MAXC = '1;

  p_ov_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_off && (ov_mem_pulse || ov_term_pulse)) |=> shutdown);

  p_rail_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_off |=> ((rail_off & $past(rail_off)) == $past(rail_off)));

  p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_off |=> (fault_count == '0 && rail_off == '0));

  p_quiet_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (fault_count == '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_off && fault_count == MAXC && |rail_hit) |=> (fault_count == MAXC));

  p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_off && |rail_hit) |=> (fault_count > $past(fault_count) || fault_count == MAXC));

  p_trip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trip_hit |=> shutdown);

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shutdown) |-> (!$past(soft_off) && $past(soft_off, 2)));

endmodule

bind fc_fault_tally fc_fault_tally_chk #(.N_RAILS(N_RAILS), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .soft_off(soft_off),
  .ov_mem_pulse(ov_mem_pulse), .ov_term_pulse(ov_term_pulse),
  .rail_off(rail_off), .shutdown(shutdown), .fault_count(fault_count),
  .rail_hit(rail_hit), .expire(expire), .trip_hit(trip_hit)
);

// File: tb/test_fc_fault_tally.sv
`timescale 1ns/1ps
module test_fc_fault_tally;
  localparam int LIM = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] uv = '0;
  logic       oc = 1'b0, ovm = 1'b0, ovt = 1'b0, rs = 1'b0, so = 1'b0;
  logic [3:0] rail_off;
  logic       shutdown;
  logic [2:0] fault_count;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fc_fault_tally #(.QUIET_LIMIT(LIM)) i_fc_fault_tally (
    .clk(clk), .rst_n(rst_n), .uv_pulse(uv), .oc_mem_pulse(oc),
    .ov_mem_pulse(ovm), .ov_term_pulse(ovt), .restart_active(rs),
    .soft_off(so), .rail_off(rail_off), .shutdown(shutdown),
    .fault_count(fault_count)
  );

  // stimulus [16:8] = uv[3:0] oc ovm ovt rs so ; expect [7:0] = rail_off[3:0] shutdown count[2:0]
  localparam logic [16:0] VEC [0:23] = '{
    17'b0000_0_0_0_0_0_0000_0_000, // R11 idle
    17'b0100_0_0_0_0_0_0100_0_001, // R1 rail2 undervoltage
    17'b0000_0_0_0_0_0_1100_0_010, // R6 rail3 follows rail2
    17'b0000_0_0_0_0_0_1100_0_010, // R1 hold
    17'b0100_0_0_0_0_0_1100_0_010, // R4 repeat on disabled rail
    17'b0000_1_0_0_0_0_1101_0_011, // R1 overcurrent on rail0
    17'b0000_0_0_0_0_0_1111_0_100, // R6 rail1 follows, R9 no trip without restart
    17'b0000_0_0_0_0_1_0000_0_000, // R10 soft-off clears
    17'b1111_1_1_1_0_1_0000_0_000, // R10 pulses ignored in soft-off
    17'b0000_0_0_0_0_0_0000_0_000, // R10 back to active
    17'b0101_0_0_0_0_0_0101_0_010, // R2 two rails in one clock
    17'b0000_0_0_0_0_0_1111_0_100, // R6 two cascades in one clock
    17'b0000_0_1_0_0_0_1111_1_101, // R7 supply overvoltage
    17'b0000_0_1_1_0_0_1111_1_111, // R2 both overvoltages count
    17'b0000_0_1_0_0_0_1111_1_111, // R3 saturation
    17'b0000_0_0_0_0_0_1111_1_111, // R8 shutdown held
    17'b0000_0_0_0_0_1_0000_1_000, // R8 held in soft-off
    17'b0000_0_0_0_0_1_0000_1_000, // R8 held in soft-off
    17'b0000_0_0_0_0_0_0000_0_000, // R8 released on leaving soft-off
    17'b0000_0_0_0_0_0_0000_0_000, // R8 stays clear
    17'b0001_0_0_0_1_0_0001_0_001, // R9 restart, first fault
    17'b0000_0_0_0_1_0_0011_0_010, // R9 cascade
    17'b0100_0_0_0_1_0_0111_0_011, // R9 third
    17'b0000_0_0_0_1_0_1111_1_100  // R9 fourth trips shutdown
  };
  localparam int VREQ [0:23] = '{11,1,6,1,4,1,6,10,10,10,2,6,7,2,3,8,8,8,8,8,9,9,9,9};

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got rail/shut/cnt %b expected %b", req, got, exp);
    end
  endtask

  task automatic drive(input logic [8:0] s);
    @(negedge clk);
    {uv, oc, ovm, ovt, rs, so} = s;
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [7:0] outs();
    return {rail_off, shutdown, fault_count};
  endfunction

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    #12;
    check("R11 reset", outs(), 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 24; k++) begin
      drive(VREQ[k] >= 0 ? VEC[k][16:8] : 9'd0);
      step();
      check($sformatf("R%0d vector %0d", VREQ[k], k), outs(), VEC[k][7:0]);
    end
    // leave the trip state through soft-off
    drive(9'b0000_0_0_0_0_1);
    step();
    drive(9'b0000_0_0_0_0_0);
    step();
    check("R8 clear after trip", outs(), 8'h00);
    // R5 quiet window restarts on a counted fault
    drive(9'b0010_0_0_0_0_0);
    step();
    check("R5 first fault", outs(), {4'b0010, 1'b0, 3'd1});
    drive(9'd0);
    for (int k = 0; k < LIM - 2; k++) step();
    drive(9'b1000_0_0_0_0_0);
    step();
    check("R5 fault inside window", outs(), {4'b1010, 1'b0, 3'd2});
    drive(9'd0);
    for (int k = 0; k < LIM - 1; k++) step();
    check("R5 one edge before expiry", outs(), {4'b1010, 1'b0, 3'd2});
    step();
    check("R5 expiry clears count only", outs(), {4'b1010, 1'b0, 3'd0});
    // R4 ignored pulse does not restart the window
    drive(9'b1000_0_0_0_0_0);
    step();
    check("R4 no count on disabled rail", outs(), {4'b1010, 1'b0, 3'd0});
    // R11 reset in mid-operation
    drive(9'b0000_0_1_0_0_0);
    step();
    check("R7 overvoltage before reset", outs(), {4'b1010, 1'b1, 3'd1});
    @(negedge clk);
    ovm = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R11 asynchronous reset", outs(), 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    summary();
  end

endmodule